// File: doc/BRIEF.md
# Bit Scan and Zero Count Unit

This execution unit returns the position of the lowest or highest set bit of an operand, or the number of trailing or leading zero bits. The operation is picked by a direction bit and a repeat-prefix flag. The repeat prefix selects counting only when the implementation reports that the counting feature exists. Without the feature, the prefix has no effect and the plain scan runs. This lets the unit reproduce either generation of processor behaviour for one and the same instruction encoding.

The two scan operations treat an all-zero source in a special way. The destination is not overwritten: the unit passes the old destination value through and drops the write enable. The two count operations always write. For a zero source they return the operand width and raise carry.

The operand width is 16, 32 or 64 bits. Source bits above the selected width are ignored. The result, the write enable and the zero and carry flags are registered and appear one clock after the input strobe.

Top module: `bit_scan_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `outValid`, `writeEn`, `zeroFlag` and `carryFlag` low.
- R2: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high. The result and flags for that input are presented in that same cycle.
- R3: `sizeSel` selects the operand width: 0 gives 16 bits, 1 gives 32 bits, and 2 or 3 give 64 bits. Source bits at or above the width have no effect. Every computed index or count is zero-extended to 64 bits.
- R4: Forward scan (`opDir`=0, count mode inactive) of a nonzero operand returns the index of the lowest set bit, with `writeEn`=1, `zeroFlag`=0 and `carryFlag`=0.
- R5: Reverse scan (`opDir`=1, count mode inactive) of a nonzero operand returns the index of the highest set bit, with `writeEn`=1, `zeroFlag`=0 and `carryFlag`=0.
- R6: A scan of a zero operand returns `oldDest` unchanged in all 64 bits, with `writeEn`=0, `zeroFlag`=1 and `carryFlag`=0.
- R7: Count mode is active only when `repPrefix`=1 and `cntSupported`=1. With `cntSupported`=0, `repPrefix` has no effect on any output.
- R8: In count mode with a nonzero operand, `opDir`=0 returns the trailing zero count and `opDir`=1 returns the leading zero count within the width. `carryFlag`=0, `zeroFlag` is 1 exactly when the count is 0, and `writeEn`=1.
- R9: In count mode with a zero operand, the result is the operand width in bits (16, 32 or 64), with `carryFlag`=1, `zeroFlag`=0 and `writeEn`=1.
- R10: In a cycle after one with `inValid` low, `result`, `zeroFlag` and `carryFlag` keep their values, and `writeEn` and `outValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation request strobe |
| opDir | input | 1 | 0: forward scan / trailing count; 1: reverse scan / leading count |
| sizeSel | input | 2 | Operand width select |
| repPrefix | input | 1 | Repeat prefix present on the instruction |
| cntSupported | input | 1 | Counting feature implemented |
| srcVal | input | 64 | Source operand |
| oldDest | input | 64 | Current destination register value |
| outValid | output | 1 | Result valid strobe |
| result | output | 64 | Value for the destination register |
| writeEn | output | 1 | Destination write enable |
| zeroFlag | output | 1 | Zero flag |
| carryFlag | output | 1 | Carry flag |

## Verification
The embedded properties relate the output strobes to the previous cycle's `inValid`. They take for granted that `inValid` is a clean, reset-defined level, never X. They also assume `sizeSel` and the mode bits are stable during the strobe cycle. The stimulus drives every input on the falling edge and returns `inValid` low between operations. The hold behaviour is exercised on purpose with changed operands while the strobe is low. Every `sizeSel` code, including the alias 3, is swept against all combinations of direction, prefix and feature flag.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_64B = 2'd3
  } opSize_e;

  typedef struct packed {
    logic capture;
    logic countMode;
    logic reverse;
    logic keepOld;
  } bsuStrobes_t;

endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        opDir,
  input  logic        repPrefix,
  input  logic        cntSupported,
  input  logic        srcZero,
  output bsuStrobes_t strb,
  output logic        outValid
);

  logic countActive;

  always_comb begin
    countActive    = repPrefix & cntSupported;
    strb.capture   = inValid;
    strb.countMode = countActive;
    strb.reverse   = opDir;
    strb.keepOld   = srcZero & ~countActive;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R10
  valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  bsuStrobes_t       strb,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] oldDest,
  input  logic              outValid,
  output logic              srcZero,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              zeroFlag,
  output logic              carryFlag
);

  localparam int IDX_W  = $clog2(DATA_W) + 1;
  localparam int HALF_W = DATA_W / 2;
  localparam int QUAR_W = DATA_W / 4;

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] srcMasked;
  logic [IDX_W-1:0]  widthBits;
  logic [IDX_W-1:0]  lowIdx;
  logic [IDX_W-1:0]  highIdx;
  logic [IDX_W-1:0]  countVal;
  logic [DATA_W-1:0] nextResult;
  logic              nextWe;
  logic              nextZf;
  logic              nextCf;

  always_comb begin
    unique case (opSize_e'(sizeSel))
      SZ_16: begin
        widthMask = {{(DATA_W-QUAR_W){1'b0}}, {QUAR_W{1'b1}}};
        widthBits = IDX_W'(QUAR_W);
      end
      SZ_32: begin
        widthMask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        widthBits = IDX_W'(HALF_W);
      end
      default: begin
        widthMask = {DATA_W{1'b1}};
        widthBits = IDX_W'(DATA_W);
      end
    endcase
    srcMasked = srcVal & widthMask;
    srcZero   = (srcMasked == '0);
  end

  // lowest set bit: the last hit scanning downward wins
  always_comb begin
    lowIdx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (srcMasked[i]) lowIdx = IDX_W'(i);
    end
  end

  // highest set bit: the last hit scanning upward wins
  always_comb begin
    highIdx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (srcMasked[i]) highIdx = IDX_W'(i);
    end
  end

  always_comb begin
    if (srcZero)          countVal = widthBits;
    else if (strb.reverse) countVal = widthBits - IDX_W'(1) - highIdx;
    else                  countVal = lowIdx;

    if (strb.countMode) begin
      nextResult = {{(DATA_W-IDX_W){1'b0}}, countVal};
      nextWe     = 1'b1;
      nextZf     = (countVal == '0);
      nextCf     = srcZero;
    end else if (strb.keepOld) begin
      nextResult = oldDest;
      nextWe     = 1'b0;
      nextZf     = 1'b1;
      nextCf     = 1'b0;
    end else begin
      nextResult = {{(DATA_W-IDX_W){1'b0}}, (strb.reverse ? highIdx : lowIdx)};
      nextWe     = 1'b1;
      nextZf     = 1'b0;
      nextCf     = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      writeEn   <= 1'b0;
      zeroFlag  <= 1'b0;
      carryFlag <= 1'b0;
    end else if (strb.capture) begin
      result    <= nextResult;
      writeEn   <= nextWe;
      zeroFlag  <= nextZf;
      carryFlag <= nextCf;
    end else begin
      writeEn   <= 1'b0;
    end
  end

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> $stable(result) && $stable(zeroFlag) && $stable(carryFlag) && !writeEn);

  // R6
  scan_zero_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !writeEn) |-> (zeroFlag && !carryFlag));

  // R9
  count_zero_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && carryFlag) |-> (writeEn && !zeroFlag && result != '0));

  // R2
  we_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    writeEn |-> outValid);

endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              opDir,
  input  logic [1:0]        sizeSel,
  input  logic              repPrefix,
  input  logic              cntSupported,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] oldDest,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              zeroFlag,
  output logic              carryFlag
);

  bsuStrobes_t strb;
  logic        srcZero;

  bsu_ctrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .inValid      (inValid),
    .opDir        (opDir),
    .repPrefix    (repPrefix),
    .cntSupported (cntSupported),
    .srcZero      (srcZero),
    .strb         (strb),
    .outValid     (outValid)
  );

  bsu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .sizeSel   (sizeSel),
    .srcVal    (srcVal),
    .oldDest   (oldDest),
    .outValid  (outValid),
    .srcZero   (srcZero),
    .result    (result),
    .writeEn   (writeEn),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag)
  );

endmodule

// File: tb/test_bit_scan_unit.sv
`timescale 1ns/1ps
module test_bit_scan_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        opDir;
  logic [1:0]  sizeSel;
  logic        repPrefix;
  logic        cntSupported;
  logic [63:0] srcVal;
  logic [63:0] oldDest;
  logic        outValid;
  logic [63:0] result;
  logic        writeEn;
  logic        zeroFlag;
  logic        carryFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  longint unsigned lcg = 64'h1234_5678_9abc_def1;

  always #5 clk = ~clk;

  bit_scan_unit i_bit_scan_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .opDir(opDir), .sizeSel(sizeSel),
    .repPrefix(repPrefix), .cntSupported(cntSupported), .srcVal(srcVal),
    .oldDest(oldDest), .outValid(outValid), .result(result), .writeEn(writeEn),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  function automatic longint unsigned nextRand();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  task automatic model(input bit dir, input bit [1:0] sz, input bit rep, input bit sup,
                       input bit [63:0] src, input bit [63:0] old,
                       output bit [63:0] r, output bit we, output bit zf, output bit cf);
    int w;
    bit [63:0] m;
    int n;
    bit hit;
    w = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
    m = '0;
    for (int i = 0; i < w; i++) m[i] = src[i];
    if (rep && sup) begin
      n = 0; hit = 0;
      if (!dir) begin
        for (int i = 0; i < w; i++) if (!hit) begin if (m[i]) hit = 1; else n++; end
      end else begin
        for (int i = w - 1; i >= 0; i--) if (!hit) begin if (m[i]) hit = 1; else n++; end
      end
      r = 64'(n); we = 1; zf = (n == 0); cf = (n == w);
    end else if (m == 0) begin
      r = old; we = 0; zf = 1; cf = 0;
    end else begin
      n = 0; hit = 0;
      if (!dir) begin
        for (int i = 0; i < w; i++) if (!hit && m[i]) begin hit = 1; n = i; end
      end else begin
        for (int i = w - 1; i >= 0; i--) if (!hit && m[i]) begin hit = 1; n = i; end
      end
      r = 64'(n); we = 1; zf = 0; cf = 0;
    end
  endtask

  task automatic check(input string tag, input bit [66:0] act, input bit [66:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual={r=%h we,zf,cf=%b} expected={r=%h we,zf,cf=%b}",
               tag, act[66:3], act[2:0], exp[66:3], exp[2:0]);
    end
  endtask

  task automatic runOp(input bit dir, input bit [1:0] sz, input bit rep, input bit sup,
                       input bit [63:0] src, input bit [63:0] old, input string tagIn);
    bit [63:0] r; bit we, zf, cf;
    string tag;
    model(dir, sz, rep, sup, src, old, r, we, zf, cf);
    if (tagIn != "") tag = tagIn;
    else if (rep && !sup) tag = "R7";
    else if (rep && sup) tag = (cf ? "R9" : "R8");
    else if (!we) tag = "R6";
    else tag = dir ? "R5" : "R4";
    @(negedge clk);
    inValid = 1; opDir = dir; sizeSel = sz; repPrefix = rep; cntSupported = sup;
    srcVal = src; oldDest = old;
    @(negedge clk);
    inValid = 0;
    checks++;
    if (outValid !== 1'b1) begin
      failures++;
      $display("FAIL R2 outValid actual=%b expected=1", outValid);
    end
    check(tag, {result, writeEn, zeroFlag, carryFlag}, {r, we, zf, cf});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit [66:0] held;
    rst = 1; inValid = 0; opDir = 0; sizeSel = 0; repPrefix = 0; cntSupported = 0;
    srcVal = 0; oldDest = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {64'd0, outValid, writeEn, zeroFlag}, {64'd0, 3'b000});
    checks++;
    if (carryFlag !== 1'b0) begin
      failures++;
      $display("FAIL R1 carryFlag actual=%b expected=0", carryFlag);
    end
    rst = 0;

    for (int sz = 0; sz < 4; sz++)
      for (int dir = 0; dir < 2; dir++)
        for (int mode = 0; mode < 4; mode++) begin
          bit rep, sup;
          rep = mode[0]; sup = mode[1];
          runOp(dir[0], sz[1:0], rep, sup, 64'd0, nextRand(), "");
          for (int b = 0; b < 64; b++) begin
            int w;
            w = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
            // R3: bits at or above the width behave as a zero operand
            runOp(dir[0], sz[1:0], rep, sup, 64'd1 << b, nextRand(), (b >= w) ? "R3" : "");
          end
          for (int k = 0; k < 8; k++)
            runOp(dir[0], sz[1:0], rep, sup, nextRand() >> (k * 7), nextRand(), "");
        end

    // R10: outputs hold with no strobe while inputs change
    runOp(1'b1, 2'd2, 1'b0, 1'b0, 64'h0000_0100_0000_0000, 64'd7, "R5");
    held = {result, 1'b0, zeroFlag, carryFlag};
    @(negedge clk);
    srcVal = 64'd0; oldDest = 64'hdead_beef; repPrefix = 1; cntSupported = 1;
    @(negedge clk);
    check("R10", {result, writeEn, zeroFlag, carryFlag}, held);
    checks++;
    if (outValid !== 1'b0) begin
      failures++;
      $display("FAIL R10 outValid actual=%b expected=0", outValid);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule